// File: doc/BRIEF.md
# Sliding Window Broadcast Buffer

This block feeds a row of parallel consumer lanes from one streaming element source. Lane k works on a window of `WIN` consecutive array elements starting at element k, so the windows of adjacent lanes share all but one element. Instead of letting every lane read its own window from memory, the buffer asks the source for each element once, in ascending index order. It keeps the most recent `WIN` elements in a shift register and broadcasts the finished window on a single shared data bus, raising the valid line of exactly one lane at a time.

A transaction starts with a one-cycle start pulse that carries a base element index and a lane count. The buffer then asks for elements `base`, `base+1`, and so on, with a request/valid handshake. Once `WIN` elements are held, each further element completes the next window. Windows go to lanes 0, 1, 2 and so on in that order. A lane that is not ready holds the element stream back, so nothing is dropped or read twice. After the last lane takes its window the buffer pulses done and becomes idle again.

Top module: `sw_bcast_buf`

## Requirements
- R1: While reset is held and after it is released, no element is requested, no lane valid is high and done is low.
- R2: A transaction with effective lane count L requests exactly L+WIN-1 elements. The requests carry the indices base, base+1, ... in ascending order, computed modulo 2^IDX_W, and no index is repeated.
- R3: The window for lane k holds the elements with indices base+k through base+k+WIN-1. The element with index base+k+j sits in bits [j*DATA_W +: DATA_W] of the window data bus.
- R4: Windows are offered in ascending lane order, with at most one lane valid at a time. Lane k becomes valid in the cycle after element base+k+WIN-1 is accepted, and no lane at or above L is ever made valid.
- R5: A lane's valid and the window data stay unchanged until that lane's ready is high. During any cycle in which an offered window is not taken, no element is requested.
- R6: Done is high for exactly one cycle, in the cycle after the handshake of the last lane. In that cycle and afterwards there are no requests and no valid lanes until the next start.
- R7: A start pulse that arrives while a transaction is running is ignored. The request indices and the window order of the running transaction are not changed.
- R8: A start with lane count 0 is ignored and produces no requests. A lane count above MAX_LANES is treated as MAX_LANES.
- R9: An element is taken only in a cycle in which both the request and the source valid are high. Source gaps only delay the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| base_i | input | IDX_W | Index of the first element of the transaction |
| lanes_i | input | clog2(MAX_LANES+1) | Number of lanes to serve |
| elem_req_o | output | 1 | Buffer asks for the element at elem_idx_o |
| elem_idx_o | output | IDX_W | Index of the requested element |
| elem_valid_i | input | 1 | Source presents the requested element |
| elem_data_i | input | DATA_W | Element value |
| win_valid_o | output | MAX_LANES | One-hot window valid per lane |
| win_ready_i | input | MAX_LANES | Per-lane ready |
| win_data_o | output | WIN*DATA_W | Broadcast window, oldest element in the lowest slot |
| done_o | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The element request and its index respond in the same cycle to the lane readies. A lane's valid is due one cycle after the edge that accepted the element completing its window. Done is due one cycle after the edge that carried the last lane handshake. The bench drives inputs at the falling edge, waits for the combinational outputs to settle, and only then samples. It keeps counts of accepted elements and completed handshakes, and these give the exact cycle in which each valid, window value and done pulse must be seen. Every sample is compared against those counts rather than against a fixed delay.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_RUN  = 1'b1
  } sw_state_e;

  // Clamp a requested lane count to the hardware maximum
  function automatic int unsigned sw_clamp(input int unsigned req, input int unsigned max_cnt);
    return (req > max_cnt) ? max_cnt : req;
  endfunction

endpackage

// File: rtl/sw_fetch_ctrl.sv
module sw_fetch_ctrl
  import sw_pkg::*;
#(
  parameter int WIN       = 4,
  parameter int MAX_LANES = 128,
  parameter int IDX_W     = 16,
  localparam int CNT_W    = $clog2(MAX_LANES + 1),
  localparam int LANE_W   = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
  localparam int FW       = $clog2(MAX_LANES + WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  base_i,
  input  logic [CNT_W-1:0]  lanes_i,
  input  logic              elem_valid_i,
  input  logic              hand_i,
  output logic              elem_req_o,
  output logic [IDX_W-1:0]  elem_idx_o,
  output logic              accept_o,
  output logic              pend_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              done_o
);

  sw_state_e          state_q, state_d;
  logic [IDX_W-1:0]   base_q, base_d;
  logic [CNT_W-1:0]   lanes_q, lanes_d;
  logic [FW-1:0]      total_q, total_d;
  logic [FW-1:0]      fetched_q, fetched_d;
  logic [LANE_W-1:0]  lane_q, lane_d;
  logic               pend_q, pend_d;
  logic               done_q, done_d;

  logic [CNT_W-1:0]   lanes_eff;
  logic               start_ok;
  logic               exhausted;
  logic               accept;
  logic               completes;
  logic               last_hand;

  always_comb begin
    lanes_eff = CNT_W'(sw_clamp(int'(lanes_i), MAX_LANES));
    start_ok  = (state_q == SW_IDLE) && start_i && (lanes_i != '0);
    exhausted = (fetched_q == total_q);
    elem_req_o = (state_q == SW_RUN) && !exhausted && (!pend_q || hand_i);
    accept    = elem_req_o && elem_valid_i;
    completes = accept && (fetched_q >= FW'(WIN - 1));
    last_hand = hand_i && (lane_q == LANE_W'(lanes_q - 1'b1));
  end

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    base_d    = base_q;
    lanes_d   = lanes_q;
    total_d   = total_q;
    fetched_d = fetched_q;
    lane_d    = lane_q;
    pend_d    = pend_q;
    done_d    = 1'b0;
    unique case (state_q)
      SW_IDLE: begin
        if (start_ok) begin
          state_d   = SW_RUN;
          base_d    = base_i;
          lanes_d   = lanes_eff;
          total_d   = FW'(lanes_eff) + FW'(WIN - 1);
          fetched_d = '0;
          lane_d    = '0;
          pend_d    = 1'b0;
        end
      end
      SW_RUN: begin
        if (accept) fetched_d = fetched_q + 1'b1;
        if (hand_i) lane_d = lane_q + 1'b1;
        pend_d = completes || (pend_q && !hand_i);
        if (last_hand) begin
          state_d = SW_IDLE;
          pend_d  = 1'b0;
          done_d  = 1'b1;
        end
      end
      default: state_d = SW_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SW_IDLE;
      base_q    <= '0;
      lanes_q   <= '0;
      total_q   <= '0;
      fetched_q <= '0;
      lane_q    <= '0;
      pend_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      base_q    <= base_d;
      lanes_q   <= lanes_d;
      total_q   <= total_d;
      fetched_q <= fetched_d;
      lane_q    <= lane_d;
      pend_q    <= pend_d;
      done_q    <= done_d;
    end
  end

  assign elem_idx_o = base_q + IDX_W'(fetched_q);
  assign accept_o   = accept;
  assign pend_o     = pend_q;
  assign lane_o     = lane_q;
  assign done_o     = done_q;

endmodule

// File: rtl/sw_shift_win.sv
module sw_shift_win #(
  parameter int DATA_W = 32,
  parameter int WIN    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_i,
  input  logic [DATA_W-1:0]     din_i,
  output logic [WIN*DATA_W-1:0] win_o
);

  logic [DATA_W-1:0] slot_q [WIN];
  logic [DATA_W-1:0] slot_d [WIN];

  // Slot 0 holds the oldest element; new data enters the top slot
  for (genvar g = 0; g < WIN; g++) begin : g_slot
    if (g == WIN - 1) begin : g_top
      always_comb slot_d[g] = din_i;
    end else begin : g_mid
      always_comb slot_d[g] = slot_q[g+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (shift_i) begin
        slot_q[g] <= slot_d[g];
      end
    end

    assign win_o[g*DATA_W +: DATA_W] = slot_q[g];
  end

endmodule

// File: rtl/sw_lane_sel.sv
module sw_lane_sel #(
  parameter int MAX_LANES = 128,
  localparam int LANE_W   = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
  input  logic [LANE_W-1:0]    lane_i,
  input  logic                 pend_i,
  input  logic [MAX_LANES-1:0] ready_i,
  output logic [MAX_LANES-1:0] valid_o,
  output logic                 hand_o
);

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    assign valid_o[g] = pend_i && (lane_i == LANE_W'(g));
  end

  assign hand_o = pend_i && ready_i[lane_i];

endmodule

// File: rtl/sw_bcast_buf.sv
module sw_bcast_buf #(
  parameter int DATA_W    = 32,
  parameter int WIN       = 4,
  parameter int MAX_LANES = 128,
  parameter int IDX_W     = 16,
  localparam int CNT_W    = $clog2(MAX_LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [IDX_W-1:0]      base_i,
  input  logic [CNT_W-1:0]      lanes_i,
  output logic                  elem_req_o,
  output logic [IDX_W-1:0]      elem_idx_o,
  input  logic                  elem_valid_i,
  input  logic [DATA_W-1:0]     elem_data_i,
  output logic [MAX_LANES-1:0]  win_valid_o,
  input  logic [MAX_LANES-1:0]  win_ready_i,
  output logic [WIN*DATA_W-1:0] win_data_o,
  output logic                  done_o
);

  localparam int LANE_W = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1;

  logic              accept;
  logic              pend;
  logic              hand;
  logic [LANE_W-1:0] lane;

  sw_fetch_ctrl #(
    .WIN       (WIN),
    .MAX_LANES (MAX_LANES),
    .IDX_W     (IDX_W)
  ) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .base_i       (base_i),
    .lanes_i      (lanes_i),
    .elem_valid_i (elem_valid_i),
    .hand_i       (hand),
    .elem_req_o   (elem_req_o),
    .elem_idx_o   (elem_idx_o),
    .accept_o     (accept),
    .pend_o       (pend),
    .lane_o       (lane),
    .done_o       (done_o)
  );

  sw_shift_win #(
    .DATA_W (DATA_W),
    .WIN    (WIN)
  ) i_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (accept),
    .din_i   (elem_data_i),
    .win_o   (win_data_o)
  );

  sw_lane_sel #(
    .MAX_LANES (MAX_LANES)
  ) i_sel (
    .lane_i  (lane),
    .pend_i  (pend),
    .ready_i (win_ready_i),
    .valid_o (win_valid_o),
    .hand_o  (hand)
  );

endmodule

// File: rtl/sw_bcast_buf_chk.sv
module sw_bcast_buf_chk #(
  parameter int DATA_W    = 32,
  parameter int WIN       = 4,
  parameter int MAX_LANES = 128,
  parameter int IDX_W     = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  elem_req_o,
  input logic [IDX_W-1:0]      elem_idx_o,
  input logic                  elem_valid_i,
  input logic [MAX_LANES-1:0]  win_valid_o,
  input logic [MAX_LANES-1:0]  win_ready_i,
  input logic [WIN*DATA_W-1:0] win_data_o,
  input logic                  done_o
);

  localparam int CW = 16;

  logic [CW-1:0] rd_cnt_q;
  logic [CW-1:0] win_cnt_q;
  logic          waiting;

  assign waiting = |(win_valid_o & ~win_ready_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt_q  <= '0;
      win_cnt_q <= '0;
    end else if (done_o) begin
      rd_cnt_q  <= '0;
      win_cnt_q <= '0;
    end else begin
      if (elem_req_o && elem_valid_i) rd_cnt_q <= rd_cnt_q + 1'b1;
      if (|(win_valid_o & win_ready_i)) win_cnt_q <= win_cnt_q + 1'b1;
    end
  end

  // R4
  onehot_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_valid_o));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |=> (win_valid_o == $past(win_valid_o)) && $stable(win_data_o));

  // R5
  stall_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !elem_req_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!elem_req_o && (win_valid_o == '0)));

  // R2
  read_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rd_cnt_q == win_cnt_q + CW'(WIN - 1)));

  // R2
  read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt_q <= CW'(MAX_LANES + WIN - 1));

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_req_o && elem_valid_i && !done_o) |=> (!elem_req_o || (elem_idx_o == $past(elem_idx_o) + 1'b1)));

endmodule

bind sw_bcast_buf sw_bcast_buf_chk #(
  .DATA_W    (DATA_W),
  .WIN       (WIN),
  .MAX_LANES (MAX_LANES),
  .IDX_W     (IDX_W)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .elem_req_o   (elem_req_o),
  .elem_idx_o   (elem_idx_o),
  .elem_valid_i (elem_valid_i),
  .win_valid_o  (win_valid_o),
  .win_ready_i  (win_ready_i),
  .win_data_o   (win_data_o),
  .done_o       (done_o)
);

// File: tb/test_sw_bcast_buf.sv
`timescale 1ns/1ps
module test_sw_bcast_buf;

  localparam int DW  = 32;
  localparam int WIN = 4;
  localparam int ML  = 128;
  localparam int IW  = 16;
  localparam int CW  = $clog2(ML + 1);

  // [31:16] base, [15:8] lanes, [7:6] source mode, [5:4] ready mode, [0] mid-run start
  localparam int NVEC = 7;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0000_6400,
    32'h0025_0150,
    32'h01F4_07A0,
    32'h0009_1461,
    32'hFFFD_0550,
    32'h0003_C850,
    32'h1234_0280
  };

  logic               clk;
  logic               rst_n;
  logic               start_i;
  logic [IW-1:0]      base_i;
  logic [CW-1:0]      lanes_i;
  logic               elem_req_o;
  logic [IW-1:0]      elem_idx_o;
  logic               elem_valid_i;
  logic [DW-1:0]      elem_data_i;
  logic [ML-1:0]      win_valid_o;
  logic [ML-1:0]      win_ready_i;
  logic [WIN*DW-1:0]  win_data_o;
  logic               done_o;

  int n_chk;
  int n_fail;
  int cycles;
  logic [15:0] lfsr;

  sw_bcast_buf #(
    .DATA_W    (DW),
    .WIN       (WIN),
    .MAX_LANES (ML),
    .IDX_W     (IW)
  ) i_sw_bcast_buf (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .base_i       (base_i),
    .lanes_i      (lanes_i),
    .elem_req_o   (elem_req_o),
    .elem_idx_o   (elem_idx_o),
    .elem_valid_i (elem_valid_i),
    .elem_data_i  (elem_data_i),
    .win_valid_o  (win_valid_o),
    .win_ready_i  (win_ready_i),
    .win_data_o   (win_data_o),
    .done_o       (done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [DW-1:0] elem_val(input logic [IW-1:0] i);
    return {i ^ 16'h5A3C, ~i + 16'd7};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run_txn(input logic [IW-1:0] base, input int lanes_raw,
                         input int smode, input int rmode, input bit mid);
    int L;
    int total;
    int exp_rd;
    int exp_lane;
    int cyc;
    bit last_seen;
    bit finished;
    bit exp_vld;
    bit rdy;
    L = (lanes_raw > ML) ? ML : lanes_raw;
    total = L + WIN - 1;
    exp_rd = 0;
    exp_lane = 0;
    cyc = 0;
    last_seen = 1'b0;
    finished = 1'b0;
    start_i = 1'b1;
    base_i  = base;
    lanes_i = CW'(lanes_raw);
    @(negedge clk);
    start_i = 1'b0;
    while (!finished && cyc < 5000) begin
      step_lfsr();
      // R7: a second start in the middle of a run
      if (mid && cyc == 3) begin
        start_i = 1'b1;
        base_i  = base + 16'd1000;
        lanes_i = CW'(5);
      end else begin
        start_i = 1'b0;
      end
      case (smode)
        0: elem_valid_i = 1'b1;
        1: elem_valid_i = lfsr[0];
        default: elem_valid_i = lfsr[0] & lfsr[1];
      endcase
      case (rmode)
        0: rdy = 1'b1;
        1: rdy = lfsr[2];
        default: rdy = lfsr[2] & lfsr[3];
      endcase
      win_ready_i = {8{lfsr}};
      if (exp_lane < ML) win_ready_i[exp_lane] = rdy;
      #1;
      elem_data_i = elem_val(elem_idx_o);
      #1;
      if (last_seen) begin
        // R6
        chk(done_o == 1'b1, "R6", "done after last handshake", 64'(done_o), 64'd1);
        chk(!elem_req_o && win_valid_o == '0, "R6", "quiet at done",
            64'(elem_req_o), 64'd0);
        finished = 1'b1;
      end else begin
        chk(done_o == 1'b0, "R6", "done early", 64'(done_o), 64'd0);
        // R4: valid due exactly when the window's last element was taken
        exp_vld = (exp_lane < L) && (exp_rd >= exp_lane + WIN);
        chk((|win_valid_o) == exp_vld, "R4", "valid timing", 64'(|win_valid_o), 64'(exp_vld));
        if (|win_valid_o) begin
          chk(win_valid_o == (ML'(1) << exp_lane), "R4", "lane order",
              64'($clog2(win_valid_o + 1'b1)), 64'(exp_lane));
          for (int j = 0; j < WIN; j++) begin
            // R3
            chk(win_data_o[j*DW +: DW] == elem_val(base + IW'(exp_lane + j)), "R3",
                "window slot", 64'(win_data_o[j*DW +: DW]),
                64'(elem_val(base + IW'(exp_lane + j))));
          end
          if (win_ready_i[exp_lane]) begin
            exp_lane = exp_lane + 1;
            if (exp_lane == L) last_seen = 1'b1;
          end else begin
            // R5
            chk(!elem_req_o, "R5", "request while window waits", 64'(elem_req_o), 64'd0);
          end
        end
        // R9: only request plus valid consumes an element
        if (elem_req_o && elem_valid_i) begin
          chk(exp_rd < total, "R2", "extra request", 64'(exp_rd), 64'(total));
          chk(elem_idx_o == base + IW'(exp_rd), "R2", "request index",
              64'(elem_idx_o), 64'(base + IW'(exp_rd)));
          exp_rd = exp_rd + 1;
        end
      end
      @(negedge clk);
      cyc = cyc + 1;
    end
    if (cyc >= 5000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog R2: got %0d reads expected %0d", exp_rd, total);
    end
    chk(exp_rd == total, "R2", "read count", 64'(exp_rd), 64'(total));
    chk(exp_lane == L, "R8", "lanes served", 64'(exp_lane), 64'(L));
    elem_valid_i = 1'b0;
    win_ready_i = '0;
    #2;
    // R6: the pulse is a single cycle
    chk(done_o == 1'b0 && !elem_req_o, "R6", "done width", 64'(done_o), 64'd0);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    cycles = 0;
    lfsr = 16'hACE1;
    rst_n = 1'b0;
    start_i = 1'b0;
    base_i = '0;
    lanes_i = '0;
    elem_valid_i = 1'b0;
    elem_data_i = '0;
    win_ready_i = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(!elem_req_o && win_valid_o == '0 && !done_o, "R1", "in reset",
        64'(elem_req_o), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!elem_req_o && win_valid_o == '0 && !done_o, "R1", "after reset",
        64'(win_valid_o != '0), 64'd0);

    for (int v = 0; v < NVEC; v++) begin
      run_txn(VEC[v][31:16], int'(VEC[v][15:8]), int'(VEC[v][7:6]),
              int'(VEC[v][5:4]), VEC[v][0]);
      @(negedge clk);
    end

    // R8: zero lane count is ignored
    start_i = 1'b1;
    base_i = 16'h0040;
    lanes_i = '0;
    elem_valid_i = 1'b1;
    win_ready_i = '1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #2;
      chk(!elem_req_o && win_valid_o == '0 && !done_o, "R8", "zero lanes",
          64'(elem_req_o), 64'd0);
      @(negedge clk);
    end

    // R7: after a run that saw a mid-run start, a fresh start still works
    run_txn(16'h0777, 3, 0, 1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule